// File: doc/BRIEF.md
# Six-Channel Serial Audio Slave Receiver

This block takes three serial audio data lanes that share one bit clock and one word-select line, all driven by an external master, and turns them into six parallel sample words: front left and right, surround left and right, center and low-frequency effects. Both incoming clocks are sampled by a faster system clock through a two-flop synchronizer. The block finds bit-clock rising edges in the system clock domain and shifts each lane's data in on those edges. The block never drives a clock. It only listens.

Each lane carries a left word while word select is low and a right word while it is high. A word is 24 bits, two's complement, most significant bit first. When the right-channel word finishes on all three lanes together, all six channel outputs update in the same cycle and a single-cycle strobe marks the new frame. A status bit reports whether any word in that frame was shorter than 24 bits. No setting depends on the frame rate, so sources from 24 kHz to 96 kHz need no reconfiguration.

Top module: `i2s_six_ch_rx`

## Requirements
- R1: While reset is high, and after it until the first frame, all six channel outputs are zero and `frame_valid` and `short_word` are low.
- R2: Data is sampled on bit-clock rising edges. The first bit of a word is the one sampled on the second rising edge after word select changes. The word is assembled most significant bit first, so the first bit lands in bit 23.
- R3: Word select low selects the left word and high selects the right word. Lane 0 feeds `front_l`/`front_r`, lane 1 feeds `surr_l`/`surr_r`, and lane 2 feeds `center` (left) and `lfe` (right).
- R4: `frame_valid` is a single-cycle pulse, raised once each time a right word completes after a left word. All six outputs take their new values in the same cycle as the pulse.
- R5: Bits received after the 24th bit of a word have no effect on the captured word.
- R6: A word of fewer than 24 bits is captured left-justified, with the missing low bits zero. In that case `short_word` is high from that frame's pulse until the next pulse. A frame made of full words clears it.
- R7: The first word boundary after reset is discarded. A frame is reported only when a complete left word is followed by a complete right word.
- R8: Capture is correct for any bit-clock rate whose high and low phases each last at least three system clocks. This covers 24 kHz to 96 kHz frames at 64 bit clocks per frame with a 50 MHz system clock.
- R9: Between pulses of `frame_valid`, all six channel outputs and `short_word` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial interface |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Serial bit clock from the external master (asynchronous) |
| ws_in | input | 1 | Word select from the master: 0 = left, 1 = right |
| sd_in | input | 3 | Serial data lanes: bit 0 front, bit 1 surround, bit 2 center/LFE |
| front_l | output | 24 | Front left sample |
| front_r | output | 24 | Front right sample |
| surr_l | output | 24 | Surround left sample |
| surr_r | output | 24 | Surround right sample |
| center | output | 24 | Center sample |
| lfe | output | 24 | Low-frequency effects sample |
| frame_valid | output | 1 | One-cycle strobe when all six outputs hold a new frame |
| short_word | output | 1 | A word of the current frame had fewer than 24 bits |

## Verification
Two events can land on the same bit-clock rising edge: the last bit of a word is shifted in, and the word-select change ends that word. The design has to include that bit in the word it latches and also clear the accumulator for the next word. The bench provokes this on every word by changing word select during the final bit of each slot. It uses slot lengths of 32, 24 and 16 bits, so the coincidence falls both after saturation and before it. A reference model predicts every frame, and the bench compares all six outputs and the short flag with that prediction on every system clock.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
  // number of serial data lanes sharing one bit clock / word select
  localparam int LANES = 3;

  // word-select level meaning
  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;
endpackage

// File: rtl/i2s_sync_bus.sv
module i2s_sync_bus #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;
endmodule

// File: rtl/i2s_frame_timer.sv
module i2s_frame_timer
  import i2s_rx_pkg::*;
#(
  parameter int WORD_W = 24,
  localparam int CW = $clog2(WORD_W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bclk_s,
  input  logic          ws_s,
  output logic          bit_stb,
  output logic [CW-1:0] bit_idx,
  output logic          bit_keep,
  output logic          word_end,
  output side_e         word_side,
  output logic          frame_evt,
  output logic          frame_short
);
  logic          bclk_q;
  logic          ws_d;
  logic [CW-1:0] cnt;
  logic          armed;
  logic          left_seen;
  logic          left_short;
  logic [CW:0]   bits_in_word;
  logic          word_short;

  assign bit_stb      = bclk_s & ~bclk_q;
  assign word_end     = bit_stb & (ws_s != ws_d);
  assign word_side    = side_e'(ws_d);
  assign bit_idx      = cnt;
  assign bit_keep     = cnt < CW'(WORD_W);
  assign bits_in_word = {1'b0, cnt} + 1'b1;
  assign word_short   = bits_in_word < (CW+1)'(WORD_W);
  assign frame_evt    = word_end & armed & left_seen & (word_side == SIDE_RIGHT);
  assign frame_short  = left_short | word_short;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q     <= 1'b0;
      ws_d       <= 1'b1;
      cnt        <= '0;
      armed      <= 1'b0;
      left_seen  <= 1'b0;
      left_short <= 1'b0;
    end else begin
      bclk_q <= bclk_s;
      if (bit_stb) begin
        ws_d <= ws_s;
        if (word_end) begin
          cnt   <= '0;
          armed <= 1'b1;
          if (armed && word_side == SIDE_LEFT) begin
            left_seen  <= 1'b1;
            left_short <= word_short;
          end else begin
            left_seen <= 1'b0;
          end
        end else if (bit_keep) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R5: the bit position never runs past the word width
  assert_cnt_cap_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(WORD_W));

  // R2: every word boundary restarts the bit position at the MSB
  assert_restart_R2: assert property (@(posedge clk) disable iff (rst)
    word_end |=> (cnt == '0));
endmodule

// File: rtl/i2s_lane_deser.sv
module i2s_lane_deser
  import i2s_rx_pkg::*;
#(
  parameter int WORD_W = 24,
  localparam int CW = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic [CW-1:0]     bit_idx,
  input  logic              bit_keep,
  input  logic              word_end,
  input  side_e             word_side,
  input  logic              sd_bit,
  output logic [WORD_W-1:0] left_word,
  output logic [WORD_W-1:0] done_word
);
  logic [WORD_W-1:0] acc;

  always_comb begin
    done_word = acc;
    if (bit_keep) done_word[WORD_W-1-int'(bit_idx)] = sd_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      left_word <= '0;
    end else if (bit_stb) begin
      if (word_end) begin
        acc <= '0;
        if (word_side == SIDE_LEFT) left_word <= done_word;
      end else begin
        acc <= done_word;
      end
    end
  end

  // R6: a new word always starts from an all-zero accumulator (zero padding)
  assert_pad_R6: assert property (@(posedge clk) disable iff (rst)
    word_end |=> (acc == '0));
endmodule

// File: rtl/i2s_six_ch_rx.sv
module i2s_six_ch_rx
  import i2s_rx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_in,
  input  logic              ws_in,
  input  logic [2:0]        sd_in,
  output logic [WORD_W-1:0] front_l,
  output logic [WORD_W-1:0] front_r,
  output logic [WORD_W-1:0] surr_l,
  output logic [WORD_W-1:0] surr_r,
  output logic [WORD_W-1:0] center,
  output logic [WORD_W-1:0] lfe,
  output logic              frame_valid,
  output logic              short_word
);
  localparam int CW     = $clog2(WORD_W + 1);
  localparam int SYNC_W = LANES + 2;
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b0, 1'b1, {LANES{1'b0}}};

  logic [SYNC_W-1:0] sync_v;
  logic              bclk_s, ws_s;
  logic [LANES-1:0]  sd_s;

  logic          bit_stb, bit_keep, word_end, frame_evt, frame_short;
  logic [CW-1:0] bit_idx;
  side_e         word_side;

  logic [WORD_W-1:0] lw   [LANES];
  logic [WORD_W-1:0] dw   [LANES];
  logic [WORD_W-1:0] oq_l [LANES];
  logic [WORD_W-1:0] oq_r [LANES];

  i2s_sync_bus #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst),
    .async_in({bclk_in, ws_in, sd_in}),
    .sync_out(sync_v)
  );
  assign {bclk_s, ws_s, sd_s} = sync_v;

  i2s_frame_timer #(.WORD_W(WORD_W)) u_timer (
    .clk(clk), .rst(rst), .bclk_s(bclk_s), .ws_s(ws_s),
    .bit_stb(bit_stb), .bit_idx(bit_idx), .bit_keep(bit_keep),
    .word_end(word_end), .word_side(word_side),
    .frame_evt(frame_evt), .frame_short(frame_short)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    i2s_lane_deser #(.WORD_W(WORD_W)) u_lane (
      .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_idx(bit_idx),
      .bit_keep(bit_keep), .word_end(word_end), .word_side(word_side),
      .sd_bit(sd_s[g]), .left_word(lw[g]), .done_word(dw[g])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        oq_l[g] <= '0;
        oq_r[g] <= '0;
      end else if (frame_evt) begin
        oq_l[g] <= lw[g];
        oq_r[g] <= dw[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_valid <= 1'b0;
      short_word  <= 1'b0;
    end else begin
      frame_valid <= frame_evt;
      if (frame_evt) short_word <= frame_short;
    end
  end

  assign front_l = oq_l[0];
  assign front_r = oq_r[0];
  assign surr_l  = oq_l[1];
  assign surr_r  = oq_r[1];
  assign center  = oq_l[2];
  assign lfe     = oq_r[2];

  // R4: the frame strobe lasts exactly one system clock
  assert_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);

  // R9: outputs hold between frame strobes
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |-> ($stable(front_l) && $stable(front_r) && $stable(surr_l)
                      && $stable(surr_r) && $stable(center) && $stable(lfe)
                      && $stable(short_word)));
endmodule

// File: tb/tb_i2s_six_ch_rx.sv
module tb_i2s_six_ch_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk_in = 1'b0;
  logic        ws_in = 1'b1;
  logic [2:0]  sd_in = '0;
  logic [23:0] front_l, front_r, surr_l, surr_r, center, lfe;
  logic        frame_valid, short_word;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  bit prev_fv = 1'b0;
  logic [31:0] lcg = 32'h1234_5678;

  // expected frame: {short, fl, fr, sl, sr, c, lfe}
  logic [144:0] exp_q[$];
  logic [144:0] cur_exp = '0;

  always #10 clk = ~clk; // 50 MHz

  i2s_six_ch_rx dut (
    .clk(clk), .rst(rst), .bclk_in(bclk_in), .ws_in(ws_in), .sd_in(sd_in),
    .front_l(front_l), .front_r(front_r), .surr_l(surr_l), .surr_r(surr_r),
    .center(center), .lfe(lfe), .frame_valid(frame_valid), .short_word(short_word)
  );

  function automatic logic [31:0] next_rand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  // captured word: first min(n,24) transmitted bits, left-justified, zero-padded
  function automatic logic [23:0] expect_word(logic [31:0] src, int n);
    logic [23:0] e = src[31:8];
    for (int k = 0; k < 24 - n; k++) e[k] = 1'b0;
    return e;
  endfunction

  task automatic wait_clk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one slot of n bits; word select flips during the last bit (one bit early)
  task automatic send_slot(bit side, int n, int h, logic [31:0] s0, logic [31:0] s1, logic [31:0] s2);
    for (int i = 0; i < n; i++) begin
      bclk_in = 1'b0;
      sd_in   = {s2[31-i], s1[31-i], s0[31-i]};
      ws_in   = (i == n - 1) ? ~side : side;
      wait_clk(h);
      bclk_in = 1'b1;
      wait_clk(h);
    end
  endtask

  task automatic send_frame(int n, int h, logic [31:0] l0, logic [31:0] r0,
                            logic [31:0] l1, logic [31:0] r1,
                            logic [31:0] l2, logic [31:0] r2);
    exp_q.push_back({(n < 24),
                     expect_word(l0, n), expect_word(r0, n),
                     expect_word(l1, n), expect_word(r1, n),
                     expect_word(l2, n), expect_word(r2, n)});
    send_slot(1'b0, n, h, l0, l1, l2);
    send_slot(1'b1, n, h, r0, r1, r2);
  endtask

  task automatic rand_frame(int n, int h);
    send_frame(n, h, next_rand(), next_rand(), next_rand(),
               next_rand(), next_rand(), next_rand());
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // per-clock comparison against the reference model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      vectors++;
      if (frame_valid && prev_fv) begin
        miscompares++;
        $display("FAIL R4 strobe longer than one cycle: actual=1 expected=0");
      end
      if (frame_valid && !prev_fv) begin
        if (exp_q.size() == 0) begin
          miscompares++;
          $display("FAIL R7 unexpected frame: actual fl=%h fr=%h expected none", front_l, front_r);
        end else begin
          cur_exp = exp_q.pop_front();
        end
      end
      if ({front_l, front_r, surr_l, surr_r, center, lfe} !== cur_exp[143:0]) begin
        miscompares++;
        $display("FAIL %s channels: actual=%h %h %h %h %h %h expected=%h",
                 frame_valid ? "R3" : "R9", front_l, front_r, surr_l, surr_r,
                 center, lfe, cur_exp[143:0]);
      end
      if (short_word !== cur_exp[144]) begin
        miscompares++;
        $display("FAIL R6 short_word: actual=%b expected=%b", short_word, cur_exp[144]);
      end
      prev_fv = frame_valid;
    end
  end

  // watchdog
  initial begin
    wait_clk(150000);
    miscompares++;
    $display("FAIL watchdog expired: actual=running expected=done");
    finish_run();
  end

  initial begin
    wait_clk(5);
    // R1: reset state
    vectors++;
    if ({front_l, front_r, surr_l, surr_r, center, lfe, frame_valid, short_word} !== '0) begin
      miscompares++;
      $display("FAIL R1 reset state: actual=%h expected=0",
               {front_l, front_r, surr_l, surr_r, center, lfe, frame_valid, short_word});
    end
    rst = 1'b0;
    wait_clk(10);

    // R7: a partial right slot before the first boundary must not produce a frame
    send_slot(1'b1, 20, 4, next_rand(), next_rand(), next_rand());

    // R2 R3: directed patterns, lane mapping and MSB-first placement
    send_frame(32, 4, 32'h8000_00FF, 32'h7FFF_FF00, 32'h0000_0100,
               32'hFFFF_FF00, 32'hA5A5_A5A5, 32'h5A5A_5A5A);
    send_frame(32, 4, 32'h1111_1100, 32'h2222_2200, 32'h3333_3300,
               32'h4444_4400, 32'h5555_5500, 32'h6666_6600);

    // R5: 32-bit slots with random trailing bits that must be ignored
    for (int f = 0; f < 6; f++) rand_frame(32, 4);

    // exact 24-bit words
    for (int f = 0; f < 3; f++) rand_frame(24, 4);

    // R6: short 16-bit words, then full words clear the flag
    for (int f = 0; f < 3; f++) rand_frame(16, 4);
    rand_frame(32, 4);
    rand_frame(20, 4);
    rand_frame(24, 4);

    // R8: slow bit clock (about 24 kHz frames) and the minimum phase length
    for (int f = 0; f < 3; f++) rand_frame(32, 16);
    for (int f = 0; f < 3; f++) rand_frame(32, 3);

    bclk_in = 1'b0;
    wait_clk(40);

    // R4: every expected frame must have been strobed
    vectors++;
    if (exp_q.size() != 0) begin
      miscompares++;
      $display("FAIL R4 missing frames: actual=%0d pending expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule